// File: doc/BRIEF.md
# Dual-Read Register File with 40-bit Pair Access

This block is the general-purpose register storage for one side of a load/store DSP datapath. It holds sixteen 32-bit registers and serves two combinational read ports and one clocked write port. Each port carries a register index and a width flag. With the flag low, the port moves a single 32-bit word. With the flag high, the port moves a 40-bit fixed-point value held in an aligned register pair.

In a pair, the even register holds the low 32 bits. The odd register directly above it holds the top 8 bits in its least significant byte. A pair write splits the 40-bit value across the two registers and clears the unused upper bits of the odd register. A pair read joins the two registers into one 40-bit result. A pair access that names an odd index raises an error flag for that cycle and has no effect. A chip uses two identical instances, one for the A side and one for the B side. Each instance feeds only its own functional units.

Reads see the write that is under way in the same cycle. This lets a value produced by a unit be used without waiting for the write to reach storage.

Top module: `pair_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. After reset, every single-width read returns zero.
- R2: A single-width write (`wrPair`=0) stores `wrData[31:0]` in register `wrIdx` on the rising clock edge. `wrData[39:32]` is ignored.
- R3: A single-width read returns the addressed register in bits 31:0. Bits 39:32 of the read data are zero.
- R4: A pair write (`wrPair`=1) to even index n stores `wrData[31:0]` in register n. It stores `wrData[39:32]` in bits 7:0 of register n+1 and clears bits 31:8 of register n+1.
- R5: A pair read at even index n returns register n in bits 31:0 and bits 7:0 of register n+1 in bits 39:32. Bits 31:8 of register n+1 do not affect the result.
- R6: A pair access at an odd index raises that port's error flag in the same cycle. A pair write at an odd index leaves every register unchanged. A pair read at an odd index returns zero. In every other case the error flags stay low.
- R7: A read of the register being written in the same cycle returns the value being written (write-first bypass).
- R8: The bypass applies to each half of a pair on its own. This holds when a pair read overlaps a single write, a single read overlaps a pair write, and a pair read overlaps a pair write.
- R9: With `wrEn` low, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write request |
| wrPair | input | 1 | Write width: 0 = 32-bit single, 1 = 40-bit pair |
| wrIdx | input | 4 | Write register index (even for pairs) |
| wrData | input | 40 | Write data; only bits 31:0 are used for single writes |
| wrErr | output | 1 | Pair write named an odd index; the write is dropped |
| rdIdxA | input | 4 | Read port A register index |
| rdPairA | input | 1 | Read port A width flag |
| rdDataA | output | 40 | Read port A data |
| rdErrA | output | 1 | Read port A pair access at an odd index |
| rdIdxB | input | 4 | Read port B register index |
| rdPairB | input | 1 | Read port B width flag |
| rdDataB | output | 40 | Read port B data |
| rdErrB | output | 1 | Read port B pair access at an odd index |

## Verification
The bench fills the odd registers with ones in bits 31:8 and then pair-reads them. A design that did not mask the high half would leak those bits into the top byte of the 40-bit result. It also pair-writes and then single-reads the odd halves, which catches a design that left stale upper bits in place.

Pair accesses at every odd index are driven with live data. A design that skipped the index check would corrupt the neighbouring pair or return nonzero data.

Every write is paired with a same-cycle read of the written register, or of the other half of the pair. This is done in all combinations of single and pair width. A bypass that only compares full indices, or only handles one width, would return the stale value.

// File: rtl/prf_pkg.sv
package prf_pkg;

  // Write strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic wrLo;   // commit the low word at the base index
    logic wrHi;   // commit the extension byte into the odd partner
    logic wrErr;  // pair request at an odd index, dropped
  } wrStrobe_t;

endpackage

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             wrEn,
  input  logic             wrPair,
  input  logic [IDX_W-1:0] wrIdx,
  output wrStrobe_t        strobe,
  output logic [IDX_W-1:0] loIdx,
  output logic [IDX_W-1:0] hiIdx
);

  logic pairOdd;

  always_comb begin
    pairOdd      = wrPair & wrIdx[0];
    strobe.wrErr = wrEn & pairOdd;
    strobe.wrLo  = wrEn & ~pairOdd;
    strobe.wrHi  = wrEn & wrPair & ~wrIdx[0];
    loIdx        = wrIdx;
    hiIdx        = {wrIdx[IDX_W-1:1], 1'b1};
  end

endmodule

// File: rtl/prf_datapath.sv
module prf_datapath
  import prf_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int WORD_W    = 32,
  parameter int EXT_W     = 8,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int LONG_W   = WORD_W + EXT_W,
  localparam int FLAT_W   = REG_COUNT * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strobe,
  input  logic [IDX_W-1:0]  loIdx,
  input  logic [IDX_W-1:0]  hiIdx,
  input  logic [LONG_W-1:0] wrData,
  output logic [FLAT_W-1:0] regFlat,
  output logic [FLAT_W-1:0] nextFlat
);

  localparam int PAD_W = WORD_W - EXT_W;

  logic [WORD_W-1:0] loWord;
  logic [WORD_W-1:0] hiWord;

  assign loWord = wrData[WORD_W-1:0];
  assign hiWord = {{PAD_W{1'b0}}, wrData[LONG_W-1:WORD_W]};

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic [WORD_W-1:0] store;
    logic [WORD_W-1:0] nextWord;

    always_comb begin
      nextWord = store;
      if (strobe.wrLo && (loIdx == IDX_W'(g))) nextWord = loWord;
      if (strobe.wrHi && (hiIdx == IDX_W'(g))) nextWord = hiWord;
    end

    always_ff @(posedge clk) begin
      if (rst) store <= '0;
      else     store <= nextWord;
    end

    assign regFlat[g*WORD_W +: WORD_W]  = store;
    assign nextFlat[g*WORD_W +: WORD_W] = nextWord;
  end

endmodule

// File: rtl/prf_read_port.sv
module prf_read_port #(
  parameter int REG_COUNT = 16,
  parameter int WORD_W    = 32,
  parameter int EXT_W     = 8,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int LONG_W   = WORD_W + EXT_W,
  localparam int FLAT_W   = REG_COUNT * WORD_W
) (
  input  logic [FLAT_W-1:0] viewFlat,
  input  logic [IDX_W-1:0]  idx,
  input  logic              pair,
  output logic [LONG_W-1:0] data,
  output logic              err
);

  logic [WORD_W-1:0] words [REG_COUNT];
  logic [IDX_W-1:0]  evenIdx;
  logic [IDX_W-1:0]  oddIdx;
  logic [WORD_W-1:0] oddWord;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_view
    assign words[g] = viewFlat[g*WORD_W +: WORD_W];
  end

  always_comb begin
    evenIdx = {idx[IDX_W-1:1], 1'b0};
    oddIdx  = {idx[IDX_W-1:1], 1'b1};
    oddWord = words[oddIdx];
    err     = pair & idx[0];
    if (err)       data = '0;
    else if (pair) data = {oddWord[EXT_W-1:0], words[evenIdx]};
    else           data = {{EXT_W{1'b0}}, words[idx]};
  end

endmodule

// File: rtl/pair_regfile.sv
module pair_regfile
  import prf_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int WORD_W    = 32,
  parameter int EXT_W     = 8,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int LONG_W   = WORD_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrPair,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [LONG_W-1:0] wrData,
  output logic              wrErr,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic              rdPairA,
  output logic [LONG_W-1:0] rdDataA,
  output logic              rdErrA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic              rdPairB,
  output logic [LONG_W-1:0] rdDataB,
  output logic              rdErrB
);

  localparam int FLAT_W  = REG_COUNT * WORD_W;
  localparam int RD_PORTS = 2;

  wrStrobe_t         strobe;
  logic [IDX_W-1:0]  loIdx;
  logic [IDX_W-1:0]  hiIdx;
  logic [FLAT_W-1:0] regFlat;
  logic [FLAT_W-1:0] nextFlat;

  logic [IDX_W-1:0]  rdIdx  [RD_PORTS];
  logic              rdPair [RD_PORTS];
  logic [LONG_W-1:0] rdData [RD_PORTS];
  logic              rdErr  [RD_PORTS];

  prf_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrPair (wrPair),
    .wrIdx  (wrIdx),
    .strobe (strobe),
    .loIdx  (loIdx),
    .hiIdx  (hiIdx)
  );

  prf_datapath #(.REG_COUNT(REG_COUNT), .WORD_W(WORD_W), .EXT_W(EXT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .loIdx    (loIdx),
    .hiIdx    (hiIdx),
    .wrData   (wrData),
    .regFlat  (regFlat),
    .nextFlat (nextFlat)
  );

  assign wrErr = strobe.wrErr;

  assign rdIdx[0]  = rdIdxA;
  assign rdPair[0] = rdPairA;
  assign rdIdx[1]  = rdIdxB;
  assign rdPair[1] = rdPairB;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    prf_read_port #(.REG_COUNT(REG_COUNT), .WORD_W(WORD_W), .EXT_W(EXT_W)) u_rd (
      .viewFlat (nextFlat),
      .idx      (rdIdx[p]),
      .pair     (rdPair[p]),
      .data     (rdData[p]),
      .err      (rdErr[p])
    );
  end

  assign rdDataA = rdData[0];
  assign rdErrA  = rdErr[0];
  assign rdDataB = rdData[1];
  assign rdErrB  = rdErr[1];

endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
  parameter int REG_COUNT = 16,
  parameter int WORD_W    = 32,
  parameter int EXT_W     = 8,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int LONG_W   = WORD_W + EXT_W,
  localparam int FLAT_W   = REG_COUNT * WORD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic              wrPair,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [LONG_W-1:0] wrData,
  input logic              wrErr,
  input logic [IDX_W-1:0]  rdIdxA,
  input logic              rdPairA,
  input logic [LONG_W-1:0] rdDataA,
  input logic              rdErrA,
  input logic [IDX_W-1:0]  rdIdxB,
  input logic              rdPairB,
  input logic [LONG_W-1:0] rdDataB,
  input logic              rdErrB,
  input logic [FLAT_W-1:0] regFlat
);

  function automatic logic [WORD_W-1:0] regAt(input logic [FLAT_W-1:0] f, input int i);
    return f[i*WORD_W +: WORD_W];
  endfunction

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (regFlat == '0));

  a_r2_single_write: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrPair) |=> regAt(regFlat, int'($past(wrIdx))) == $past(wrData[WORD_W-1:0]));

  a_r4_pair_high_half: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrPair && !wrIdx[0]) |=>
      regAt(regFlat, int'($past(wrIdx)) + 1) == WORD_W'($past(wrData[LONG_W-1:WORD_W])));

  a_r3_single_upper_zero_a: assert property (@(posedge clk) disable iff (rst)
    !rdPairA |-> (rdDataA[LONG_W-1:WORD_W] == '0));

  a_r3_single_upper_zero_b: assert property (@(posedge clk) disable iff (rst)
    !rdPairB |-> (rdDataB[LONG_W-1:WORD_W] == '0));

  a_r6_odd_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrPair && wrIdx[0]) |=> $stable(regFlat));

  a_r6_odd_write_flag: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrPair && wrIdx[0]) |-> wrErr);

  a_r6_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rdErrA |-> rdDataA == '0) and (rdErrB |-> rdDataB == '0));

  a_r7_bypass_single: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrPair && !rdPairA && rdIdxA == wrIdx) |-> rdDataA == LONG_W'(wrData[WORD_W-1:0]));

  a_r8_bypass_pair: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrPair && !wrIdx[0] && rdPairB && rdIdxB == wrIdx) |-> rdDataB == wrData);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(regFlat));

endmodule

bind pair_regfile prf_checker #(.REG_COUNT(REG_COUNT), .WORD_W(WORD_W), .EXT_W(EXT_W)) u_chk (.*);

// File: tb/pair_regfile_tb.sv
module pair_regfile_tb;
  localparam int N = 16, W = 32, E = 8, L = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, wrEn, wrPair, wrErr;
  logic [3:0] wrIdx, rdIdxA, rdIdxB;
  logic [L-1:0] wrData, rdDataA, rdDataB;
  logic rdPairA, rdPairB, rdErrA, rdErrB;

  pair_regfile u_dut (.*);

  logic [W-1:0] model [N];
  logic [W-1:0] saved [N];
  int errs = 0, checks = 0;

  task automatic check(string req, logic [L-1:0] act, logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] modelRead(int idx, bit pair);
    if (pair) begin
      if (idx % 2 == 1) return '0;
      return {model[idx+1][E-1:0], model[idx]};
    end
    return {8'h00, model[idx]};
  endfunction

  task automatic commit(int idx, bit pair, logic [L-1:0] d, bit en);
    if (!en) return;
    if (pair) begin
      if (idx % 2 == 0) begin
        model[idx]   = d[W-1:0];
        model[idx+1] = {24'h0, d[L-1:W]};
      end
    end else model[idx] = d[W-1:0];
  endtask

  // One write cycle with port A reading in the same cycle (bypass view).
  task automatic wrStep(int idx, bit pair, logic [L-1:0] d, bit en,
                        int ra, bit pa, string req);
    logic [L-1:0] exp;
    @(negedge clk);
    wrEn = en; wrPair = pair; wrIdx = 4'(idx); wrData = d;
    rdIdxA = 4'(ra); rdPairA = pa;
    #5;
    saved = model;
    commit(idx, pair, d, en);
    exp = modelRead(ra, pa);
    model = saved;
    check(req, rdDataA, exp);
    check("R6 write flag", {39'h0, wrErr}, {39'h0, (en && pair && (idx % 2 == 1))});
    @(posedge clk);
    commit(idx, pair, d, en);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic rdCheck(int ia, bit pa, int ib, bit pb, string req);
    @(negedge clk);
    wrEn = 1'b0;
    rdIdxA = 4'(ia); rdPairA = pa; rdIdxB = 4'(ib); rdPairB = pb;
    #5;
    check(req, rdDataA, modelRead(ia, pa));
    check(req, rdDataB, modelRead(ib, pb));
    check({req, " R6 flag"}, {39'h0, rdErrA}, {39'h0, (pa && (ia % 2 == 1))});
    check({req, " R6 flag"}, {39'h0, rdErrB}, {39'h0, (pb && (ib % 2 == 1))});
  endtask

  task automatic sweepSingle(string req);
    for (int i = 0; i < N; i++) rdCheck(i, 1'b0, N - 1 - i, 1'b0, req);
  endtask

  task automatic sweepPair(string req);
    for (int i = 0; i < N; i += 2) rdCheck(i, 1'b1, i + 1, 1'b0, req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) model[i] = '0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    rst = 1'b1; wrEn = 1'b0; wrPair = 1'b0; wrIdx = '0; wrData = '0;
    rdIdxA = '0; rdPairA = 1'b0; rdIdxB = '0; rdPairB = 1'b0;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sweepSingle("R1 after reset");

    // R2 R7: single writes with junk extension byte, read back in the same cycle
    for (int i = 0; i < N; i++)
      wrStep(i, 1'b0, {8'hC3 ^ 8'(i), 32'h9E37_79B9 ^ (32'h0101_0101 * i)}, 1'b1,
             i, 1'b0, "R7 single bypass");
    sweepSingle("R2 R3 single readback");

    // R4 R8: pair writes, bypass on pair read or on the odd half
    for (int i = 0; i < N; i += 2)
      wrStep(i, 1'b1, {8'h5A + 8'(i), 32'hA000_0000 + 32'(i * 77)}, 1'b1,
             (i % 4 == 0) ? i : i + 1, (i % 4 == 0), "R8 pair bypass");
    sweepPair("R4 R5 pair readback");
    sweepSingle("R4 odd upper cleared");

    // R5 R8: fill odd halves with ones above the byte, pair read sees the write
    for (int i = 1; i < N; i += 2)
      wrStep(i, 1'b0, {8'hFF, 24'hFFFF_FF, 8'(i * 13)}, 1'b1, i - 1, 1'b1, "R8 half bypass");
    sweepPair("R5 upper bits ignored");

    // R6: pair accesses at odd indices
    for (int i = 1; i < N; i += 2)
      wrStep(i, 1'b1, 40'hDE_ADBE_EF00 + 40'(i), 1'b1, i, 1'b0, "R6 odd pair write");
    sweepSingle("R6 nothing changed");
    for (int i = 1; i < N; i += 2) rdCheck(i, 1'b1, i - 1, 1'b1, "R6 odd pair read");

    // R9: write strobe low
    for (int i = 0; i < N; i += 3)
      wrStep(i, i % 2 == 0, 40'h12_3456_789A, 1'b0, i, 1'b0, "R9 idle bypass");
    sweepSingle("R9 idle no change");

    doReset();
    sweepSingle("R1 mid-run reset");
    sweepPair("R1 pair after reset");

    finishRun();
  end

endmodule